// File: doc/BRIEF.md
# Signed-Compare Execute Unit

This block is the execute stage of a small 16-bit processor in which every instruction writes its result back to its first register operand. It receives the decoded instruction: a 4-bit major opcode, a 4-bit sub-operation field, an immediate-select bit, the values of the two register operands and a 7-bit immediate. From these it forms a result word and a write-enable for the destination register. Both outputs are combinational and belong to the cycle in which the instruction is presented.

Compare instructions do not produce a register result. They update a persistent one-bit flag that later conditional branches read. The flag is a register that updates on the clock edge that ends the compare, so the very next instruction sees the new value. Every comparison treats its operands as signed two's-complement numbers.

A two-flop synchronizer releases the internal reset. It asserts asynchronously when `rst_n` falls and deasserts on the second rising clock edge after `rst_n` rises.

Top module: `exu_core`

## Requirements
- R1: Opcode 0001 adds and opcode 0010 subtracts (first operand minus second). With `imm_sel_i`=0 the second operand is `b_i`. With `imm_sel_i`=1 it is `imm_i` sign-extended to 16 bits. The result wraps modulo 2^16 and `wr_en_o` is 1.
- R2: Opcode 0011 multiplies the two operands, with the second operand chosen as in R1. The result is the low 16 bits of the product and `wr_en_o` is 1.
- R3: Opcode 0100 divides signed, with the second operand chosen as in R1. The quotient truncates toward zero. The case -32768 / -1 gives 0x8000.
- R4: For opcode 0100, a zero divisor gives a result of 0xFFFF with `wr_en_o`=1, and the flag does not change.
- R5: Opcode 0100 is not the only one with a second-operand rule. Opcode 1001 shifts `a_i` by the signed amount held in `b_i`. With `sub_i[0]`=0 the shift goes right and with `sub_i[0]`=1 it goes left. A negative amount reverses the direction. Vacated bits are filled with zeros. A magnitude of 16 or more gives 0.
- R6: Opcode 1010 selects a logic operation with `sub_i[1:0]`: 00 is AND, 01 is the bitwise inverse of `a_i` (`b_i` is ignored), 10 is OR and 11 is XOR.
- R7: Opcode 1011 is a copy. With `imm_sel_i`=0 the result is `b_i`. With `imm_sel_i`=1 the result is the sign-extended immediate.
- R8: Opcode 1100 is a compare, and `sub_i` selects the relation. Register forms compare `a_i` with `b_i`: 0000 is ==, 0001 is <, 0010 is <=, 0011 is >, 0100 is >=. Immediate forms compare `a_i` with the sign-extended immediate: 0101 is ==, 0111 is <, 1000 is <=, 1001 is >, 1010 is >=. The comparison is signed and `imm_sel_i` has no effect on it. On the next clock edge `flag_o` becomes 1 if the relation holds and 0 if it does not. `wr_en_o` is 0 and the result is 0.
- R9: The compare codes 0110 and 1011 through 1111 leave `flag_o` unchanged.
- R10: Opcode 0000 and the opcodes that are not executed here (0101–1000 and 1101–1111) give `wr_en_o`=0 and a result of 0, and leave `flag_o` unchanged.
- R11: While reset is active, and after it is released until the first valid compare, `flag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Major opcode |
| sub_i | input | 4 | Sub-operation field (direction, logic select, compare code) |
| imm_sel_i | input | 1 | Selects the immediate as the second operand |
| a_i | input | 16 | First register operand (destination value) |
| b_i | input | 16 | Second register operand |
| imm_i | input | 7 | Signed immediate |
| result_o | output | 16 | Result word for the first register |
| wr_en_o | output | 1 | Destination register write-enable |
| flag_o | output | 1 | Registered compare flag |

## Verification
On every cycle, properties check the following:
- A compare never raises the write-enable.
- The flag holds its value unless a valid compare code is present.
- After a valid compare, the flag equals the decoded relation from the previous cycle.
- Idle opcodes drive zero.
- A zero divisor yields all ones.
- Any shift magnitude of 16 or more yields zero.
- Unused compare codes never decode as valid.

The arithmetic values themselves can only be shown by the bench's scenarios. These include:
- signed truncation of the quotient and the -32768 / -1 case;
- wrap-around of add, subtract and multiply;
- sign extension of the immediate;
- reversal of direction for negative shift amounts;
- the signed ordering at the ±1 and most-negative boundaries;
- the flag becoming visible to the very next instruction.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam logic [3:0] OP_NOP = 4'b0000;
  localparam logic [3:0] OP_ADD = 4'b0001;
  localparam logic [3:0] OP_SUB = 4'b0010;
  localparam logic [3:0] OP_MUL = 4'b0011;
  localparam logic [3:0] OP_DIV = 4'b0100;
  localparam logic [3:0] OP_SHF = 4'b1001;
  localparam logic [3:0] OP_LOG = 4'b1010;
  localparam logic [3:0] OP_CPY = 4'b1011;
  localparam logic [3:0] OP_CMP = 4'b1100;

  typedef enum logic [2:0] {
    REL_EQ = 3'd0,
    REL_LT = 3'd1,
    REL_LE = 3'd2,
    REL_GT = 3'd3,
    REL_GE = 3'd4
  } rel_e;
endpackage

// File: rtl/exu_arith.sv
module exu_arith
  import exu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  logic                 den_zero;
  logic signed [DW:0]   num_x;
  logic signed [DW:0]   den_x;
  logic signed [DW:0]   quot_x;

  // Operands are extended by one bit so that -2^(DW-1) / -1 cannot overflow.
  assign den_zero = (b == '0);
  assign num_x    = $signed({a[DW-1], a});
  assign den_x    = den_zero ? $signed({{DW{1'b0}}, 1'b1}) : $signed({b[DW-1], b});
  assign quot_x   = num_x / den_x;

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_DIV:  y = den_zero ? '1 : quot_x[DW-1:0];
      default: y = '0;
    endcase
  end

  // R4
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DIV && b == '0) |-> (y == '1));
endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_left,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] amt,
  output logic [DW-1:0] y
);
  localparam logic [DW:0] ONE_X   = (DW+1)'(1);
  localparam logic [DW:0] LIMIT_X = (DW+1)'(DW);

  logic          neg;
  logic          eff_left;
  logic [DW:0]   mag;

  // The magnitude is one bit wider, so the most negative amount stays large.
  assign neg      = amt[DW-1];
  assign mag      = neg ? ({1'b0, ~amt} + ONE_X) : {1'b0, amt};
  assign eff_left = dir_left ^ neg;
  assign y        = eff_left ? (a << mag) : (a >> mag);

  // R5
  big_shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mag >= LIMIT_X) |-> (y == '0));
endmodule

// File: rtl/exu_cmp.sv
module exu_cmp
  import exu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    code,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] imm_ext,
  output logic          valid,
  output logic          hit
);
  rel_e          rel;
  logic          use_imm;
  logic [DW-1:0] rhs;

  always_comb begin
    valid   = 1'b1;
    use_imm = 1'b0;
    rel     = REL_EQ;
    unique case (code)
      4'b0000: rel = REL_EQ;
      4'b0001: rel = REL_LT;
      4'b0010: rel = REL_LE;
      4'b0011: rel = REL_GT;
      4'b0100: rel = REL_GE;
      4'b0101: begin rel = REL_EQ; use_imm = 1'b1; end
      4'b0111: begin rel = REL_LT; use_imm = 1'b1; end
      4'b1000: begin rel = REL_LE; use_imm = 1'b1; end
      4'b1001: begin rel = REL_GT; use_imm = 1'b1; end
      4'b1010: begin rel = REL_GE; use_imm = 1'b1; end
      default: valid = 1'b0;
    endcase
  end

  assign rhs = use_imm ? imm_ext : b;

  always_comb begin
    unique case (rel)
      REL_EQ:  hit = (a == rhs);
      REL_LT:  hit = ($signed(a) <  $signed(rhs));
      REL_LE:  hit = ($signed(a) <= $signed(rhs));
      REL_GT:  hit = ($signed(a) >  $signed(rhs));
      REL_GE:  hit = ($signed(a) >= $signed(rhs));
      default: hit = 1'b0;
    endcase
  end

  // R8
  eq_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 4'b0000 && a == b) |-> (valid && hit));

  // R9
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 4'b0110 || code >= 4'b1011) |-> !valid);
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned IMMW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op_i,
  input  logic [3:0]      sub_i,
  input  logic            imm_sel_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [IMMW-1:0] imm_i,
  output logic [DW-1:0]   result_o,
  output logic            wr_en_o,
  output logic            flag_o
);
  localparam int unsigned EXTW = DW - IMMW;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [DW-1:0] imm_ext;
  logic [DW-1:0] opnd_b;
  logic [DW-1:0] arith_y;
  logic [DW-1:0] shift_y;
  logic [DW-1:0] logic_y;
  logic          cmp_valid;
  logic          cmp_hit;
  logic          flag_en;
  logic          flag_d;
  logic          flag_q;

  // Reset asserts asynchronously and releases on the second rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign imm_ext = {{EXTW{imm_i[IMMW-1]}}, imm_i};
  assign opnd_b  = imm_sel_i ? imm_ext : b_i;

  exu_arith #(.DW(DW)) u_arith (
    .clk   (clk),
    .rst_n (rst_int_n),
    .op    (op_i),
    .a     (a_i),
    .b     (opnd_b),
    .y     (arith_y)
  );

  exu_shift #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .dir_left (sub_i[0]),
    .a        (a_i),
    .amt      (b_i),
    .y        (shift_y)
  );

  exu_cmp #(.DW(DW)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .code    (sub_i),
    .a       (a_i),
    .b       (b_i),
    .imm_ext (imm_ext),
    .valid   (cmp_valid),
    .hit     (cmp_hit)
  );

  always_comb begin
    unique case (sub_i[1:0])
      2'b00:   logic_y = a_i & b_i;
      2'b01:   logic_y = ~a_i;
      2'b10:   logic_y = a_i | b_i;
      default: logic_y = a_i ^ b_i;
    endcase
  end

  always_comb begin
    result_o = '0;
    wr_en_o  = 1'b0;
    unique case (op_i)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin result_o = arith_y; wr_en_o = 1'b1; end
      OP_SHF:  begin result_o = shift_y; wr_en_o = 1'b1; end
      OP_LOG:  begin result_o = logic_y; wr_en_o = 1'b1; end
      OP_CPY:  begin result_o = opnd_b;  wr_en_o = 1'b1; end
      default: begin result_o = '0;      wr_en_o = 1'b0; end
    endcase
  end

  // The flag register: next state first, then the register with its enable.
  assign flag_en = (op_i == OP_CMP) && cmp_valid;
  always_comb begin
    flag_d = flag_q;
    if (flag_en) flag_d = cmp_hit;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) flag_q <= 1'b0;
    else            flag_q <= flag_d;
  end
  assign flag_o = flag_q;

  // R8
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_i == OP_CMP) |-> (!wr_en_o && result_o == '0));

  // R8
  flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_i == OP_CMP && cmp_valid) |=> (flag_o == $past(cmp_hit)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(op_i == OP_CMP && cmp_valid) |=> $stable(flag_o));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_i == OP_NOP) |-> (!wr_en_o && result_o == '0));
endmodule

// File: tb/exu_core_tb.sv
`timescale 1ns/1ps
module exu_core_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [3:0]  sub_i;
  logic        imm_sel_i;
  logic [15:0] a_i;
  logic [15:0] b_i;
  logic [6:0]  imm_i;
  logic [15:0] result_o;
  logic        wr_en_o;
  logic        flag_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  bit model_flag = 1'b0;

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic        flag;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  exu_core u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .sub_i(sub_i), .imm_sel_i(imm_sel_i),
    .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flag_o(flag_o)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent model of the requirements.
  task automatic model(input [3:0] op, input [3:0] sub, input bit isel, input [15:0] a,
                       input [15:0] b, input [6:0] imm, output item_t it);
    logic [15:0] ie, bo;
    int sa, sb, amt, x, y;
    bit left, h, ok;
    ie = {{9{imm[6]}}, imm};
    bo = isel ? ie : b;
    it.res = 16'h0; it.we = 1'b0;
    case (op)
      4'b0001: begin it.res = a + bo; it.we = 1; end
      4'b0010: begin it.res = a - bo; it.we = 1; end
      4'b0011: begin it.res = a * bo; it.we = 1; end
      4'b0100: begin
        it.we = 1;
        if (bo == 0) it.res = 16'hFFFF;
        else begin sa = $signed(a); sb = $signed(bo); sa = sa / sb; it.res = sa[15:0]; end
      end
      4'b1001: begin
        it.we = 1; amt = $signed(b); left = sub[0];
        if (amt < 0) begin left = !left; amt = -amt; end
        if (amt >= 16) it.res = 0;
        else it.res = left ? (a << amt) : (a >> amt);
      end
      4'b1010: begin
        it.we = 1;
        case (sub[1:0])
          2'b00: it.res = a & b;
          2'b01: it.res = ~a;
          2'b10: it.res = a | b;
          default: it.res = a ^ b;
        endcase
      end
      4'b1011: begin it.we = 1; it.res = bo; end
      4'b1100: begin
        x = $signed(a); ok = 1; h = 0;
        y = (sub <= 4) ? $signed(b) : $signed(ie);
        case (sub)
          0, 5: h = (x == y);
          1, 7: h = (x < y);
          2, 8: h = (x <= y);
          3, 9: h = (x > y);
          4, 10: h = (x >= y);
          default: ok = 0;
        endcase
        if (ok) model_flag = h;
      end
      default: ;
    endcase
    it.flag = model_flag;
  endtask

  task automatic issue(input string req, input [3:0] op, input [3:0] sub, input bit isel,
                       input [15:0] a, input [15:0] b, input [6:0] imm);
    item_t it;
    @(negedge clk);
    op_i = op; sub_i = sub; imm_sel_i = isel; a_i = a; b_i = b; imm_i = imm;
    model(op, sub, isel, a, b, imm, it);
    it.req = req;
    sb_q.push_back(it);
  endtask

  // Monitor: results of the instruction held across this edge, flag after it.
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.req, "result", result_o, it.res);
      check(it.req, "wr_en", {15'b0, wr_en_o}, {15'b0, it.we});
      check(it.req, "flag", {15'b0, flag_o}, {15'b0, it.flag});
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_i = 0; sub_i = 0; imm_sel_i = 0; a_i = 0; b_i = 0; imm_i = 0;
    repeat (3) @(negedge clk);
    // R11 flag low while reset is active
    check("R11", "flag in reset", {15'b0, flag_o}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    issue("R11", 4'b0000, 0, 0, 16'h1234, 16'h5678, 7'h00);
    // R1 add/sub, register and immediate, wrap
    issue("R1", 4'b0001, 0, 0, 16'h7FFF, 16'h0001, 7'h00);
    issue("R1", 4'b0001, 0, 1, 16'h0010, 16'hAAAA, 7'h7F);
    issue("R1", 4'b0010, 0, 0, 16'h0000, 16'h0001, 7'h00);
    issue("R1", 4'b0010, 0, 1, 16'h0005, 16'h0000, 7'h40);
    // R2 multiply low half
    issue("R2", 4'b0011, 0, 0, 16'h1234, 16'h0100, 7'h00);
    issue("R2", 4'b0011, 0, 1, 16'h0003, 16'h0000, 7'h7E);
    // R3 signed divide truncating toward zero
    issue("R3", 4'b0100, 0, 0, 16'hFFF9, 16'h0002, 7'h00);
    issue("R3", 4'b0100, 0, 1, 16'h0007, 16'h0000, 7'h7E);
    issue("R3", 4'b0100, 0, 0, 16'h8000, 16'hFFFF, 7'h00);
    // R8 set flag, then R4 divide by zero must not touch it
    issue("R8", 4'b1100, 4'b0001, 0, 16'hFFFF, 16'h0001, 7'h00);
    issue("R4", 4'b0100, 0, 0, 16'h1234, 16'h0000, 7'h00);
    issue("R4", 4'b0100, 0, 1, 16'h8000, 16'h1111, 7'h00);
    // R5 shifts
    issue("R5", 4'b1001, 0, 0, 16'h8001, 16'h0004, 7'h00);
    issue("R5", 4'b1001, 1, 0, 16'h8001, 16'h0004, 7'h00);
    issue("R5", 4'b1001, 0, 0, 16'h00F0, 16'hFFFC, 7'h00);
    issue("R5", 4'b1001, 1, 0, 16'h00F0, 16'hFFFE, 7'h00);
    issue("R5", 4'b1001, 1, 0, 16'hFFFF, 16'h0010, 7'h00);
    issue("R5", 4'b1001, 0, 0, 16'hFFFF, 16'h000F, 7'h00);
    issue("R5", 4'b1001, 0, 0, 16'hFFFF, 16'h8000, 7'h00);
    // R6 logic
    issue("R6", 4'b1010, 4'b0000, 0, 16'hF0F0, 16'hFF00, 7'h00);
    issue("R6", 4'b1010, 4'b0001, 0, 16'hF0F0, 16'hFF00, 7'h00);
    issue("R6", 4'b1010, 4'b0010, 0, 16'hF0F0, 16'hFF00, 7'h00);
    issue("R6", 4'b1010, 4'b0011, 0, 16'hF0F0, 16'hFF00, 7'h00);
    // R7 copy
    issue("R7", 4'b1011, 0, 0, 16'h1111, 16'hBEEF, 7'h00);
    issue("R7", 4'b1011, 0, 1, 16'h1111, 16'hBEEF, 7'h41);
    // R8 all relations, signed, back-to-back
    issue("R8", 4'b1100, 4'b0000, 0, 16'h8000, 16'h8000, 7'h00);
    issue("R8", 4'b1100, 4'b0000, 1, 16'h0001, 16'h0002, 7'h01);
    issue("R8", 4'b1100, 4'b0001, 0, 16'h0001, 16'hFFFF, 7'h00);
    issue("R8", 4'b1100, 4'b0010, 0, 16'h8000, 16'h8000, 7'h00);
    issue("R8", 4'b1100, 4'b0011, 0, 16'h7FFF, 16'h8000, 7'h00);
    issue("R8", 4'b1100, 4'b0100, 0, 16'hFFFE, 16'hFFFF, 7'h00);
    issue("R8", 4'b1100, 4'b0101, 0, 16'hFFC0, 16'h0000, 7'h40);
    issue("R8", 4'b1100, 4'b0111, 0, 16'hFFBF, 16'h0000, 7'h40);
    issue("R8", 4'b1100, 4'b1000, 0, 16'h0005, 16'h0000, 7'h05);
    issue("R8", 4'b1100, 4'b1001, 0, 16'h0000, 16'h0000, 7'h7F);
    issue("R8", 4'b1100, 4'b1010, 0, 16'h0002, 16'h0000, 7'h03);
    // R9 unused compare codes hold the flag (test with flag at 0 and at 1)
    issue("R9", 4'b1100, 4'b0110, 0, 16'h0001, 16'h0001, 7'h01);
    issue("R8", 4'b1100, 4'b0000, 0, 16'h0003, 16'h0003, 7'h00);
    issue("R9", 4'b1100, 4'b0110, 0, 16'h0001, 16'h0002, 7'h00);
    issue("R9", 4'b1100, 4'b1111, 0, 16'h0001, 16'h0002, 7'h00);
    issue("R9", 4'b1100, 4'b1011, 0, 16'h0001, 16'h0002, 7'h00);
    // R10 idle and non-executed opcodes
    issue("R10", 4'b0000, 0, 1, 16'hFFFF, 16'hFFFF, 7'h7F);
    issue("R10", 4'b0101, 0, 0, 16'h1234, 16'h4321, 7'h00);
    issue("R10", 4'b1000, 0, 1, 16'h1234, 16'h4321, 7'h3F);
    issue("R10", 4'b1111, 4'b0000, 0, 16'h0001, 16'h0001, 7'h00);
    issue("R10", 4'b0000, 0, 0, 16'h0000, 16'h0000, 7'h00);
    @(negedge clk);
    op_i = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule